// File: doc/BRIEF.md
# Code Flash Byte-Program Sequencer

This block is the programming-mode front end of a 4 KB by 8-bit on-chip code flash. An external programmer presents a 12-bit address, an 8-bit data byte, a 2-bit mode code, a flag that says the programming high voltage is present, and an active-low program pulse. From these the block performs byte writes, verify reads, whole-array erase and identity-byte reads. Read results come back on an output data bus with an enable. A ready line reports progress.

A byte write starts on the falling edge of the program pulse. The address and data are captured on that edge. After that the write times itself with a cycle counter that models the real programming time of up to about 1.5 ms. The programmer can watch progress in two ways. It can watch the ready line, or it can read back the address being written: while the write runs, bit 7 of that read returns the inverse of the new bit 7. A write can only clear bits. A byte that already holds data keeps the AND of its old and new values, and only a chip erase returns it to all ones. A chip erase needs the pulse held low for a long, parameterised time. It then fills the array with FFH, one location per cycle.

The array is a behavioural dual-port memory inside the design. One port serves host reads, and the other serves the sequencer's read-modify-write and erase sweep.

Top module: `flash_prog_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, ready_o is 1, data_oe_o is 0 and data_o is 00H.
- R2: A byte write starts when a falling edge of prog_n_i is sampled while mode_i is 01 (write), hv_ok_i is 1 and the block is ready. ready_o goes low on the next clock edge and stays low for exactly WRITE_CYCLES+2 cycles.
- R3: When the write completes, the addressed byte holds the bitwise AND of its previous content and the written data. On a blank byte (FFH) this is the written data itself.
- R4: While a write is in progress, a verify read (mode 00) of the address being written returns the inverse of the new data's bit 7 in bit 7. Bits 6..0 of that read hold the byte's previous content.
- R5: While a write is in progress, a verify read of any other address returns its stored content.
- R6: The address and data are captured at the starting edge. Changes on addr_i and data_i after that edge do not affect the write in progress.
- R7: A falling edge of prog_n_i while the block is busy has no effect. The busy time does not change, and the byte it addresses stays unchanged.
- R8: A write pulse with hv_ok_i at 0 is rejected. ready_o stays 1 and the addressed byte stays unchanged.
- R9: A chip erase needs mode_i at 10, hv_ok_i at 1 and prog_n_i held low for ERASE_HOLD consecutive clock edges. ready_o then goes low on the ERASE_HOLD-th edge, stays low for 2^ADDR_W cycles, and afterwards every byte reads FFH. A shorter low pulse does nothing.
- R10: In signature mode (mode 11), address 030H reads 1EH and 031H reads 51H. Address 032H reads FFH, or 05H when LOW_VPP is 1. Every other address reads 00H.
- R11: data_o shows the result for the address and mode applied two clock edges earlier. data_oe_o is 1 only for modes 00 and 11; otherwise data_o is 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 12 | Byte address |
| data_i | input | 8 | Data to write |
| mode_i | input | 2 | 00 verify, 01 write, 10 chip erase, 11 signature |
| hv_ok_i | input | 1 | Programming high voltage present |
| prog_n_i | input | 1 | Active-low program pulse |
| data_o | output | 8 | Read data |
| data_oe_o | output | 1 | Read data bus enable |
| ready_o | output | 1 | 1 when idle, 0 while a write or erase runs |

## Verification
The hardest case to reach from the ports is a second program pulse that arrives in the middle of a running write. It has to land after the start edge and before completion, and it has to carry different address and data. The bench reaches it by scheduling that pulse a fixed number of cycles after the start edge of a directed write. In the same window the bench changes the input buses and issues poll reads. Random writes are aimed at a small address window, so that many of them land on bytes that are already programmed. This exercises the AND rule against a bench model of the array.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    MODE_VERIFY = 2'b00,
    MODE_WRITE  = 2'b01,
    MODE_ERASE  = 2'b10,
    MODE_SIG    = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BUSY,
    ST_FETCH,
    ST_COMMIT,
    ST_ERASE
  } state_e;
endpackage

// File: rtl/flash_array.sv
module flash_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_q,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_we,
  input  logic [DATA_W-1:0] b_wd,
  output logic [DATA_W-1:0] b_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // host read port
  always_ff @(posedge clk) begin
    rd_q <= mem[rd_addr];
  end

  // sequencer read/write port
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wd;
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 18000,
  parameter int ERASE_HOLD   = 120000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_i,
  input  logic              hv_ok_i,
  input  logic              prog_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] old_q,
  output logic              ready_o,
  output logic              wr_busy_o,
  output logic [ADDR_W-1:0] lat_addr_o,
  output logic              poll_bit_o,
  output logic [ADDR_W-1:0] b_addr,
  output logic              b_we,
  output logic [DATA_W-1:0] b_wd
);
  localparam int CW = $clog2(WRITE_CYCLES + 1);
  localparam int HW = $clog2(ERASE_HOLD + 1);

  state_e            state;
  logic              prog_q, armed, ready_q;
  logic [CW-1:0]     wcnt;
  logic [HW-1:0]     hcnt;
  logic [ADDR_W-1:0] ptr, lat_addr;
  logic [DATA_W-1:0] lat_data;
  logic              fall, start_wr, erase_cond;

  assign fall       = prog_q & ~prog_n_i;
  assign start_wr   = (state == ST_IDLE) && fall && (mode_e'(mode_i) == MODE_WRITE) && hv_ok_i;
  assign erase_cond = (state == ST_IDLE) && (mode_e'(mode_i) == MODE_ERASE) && hv_ok_i
                      && !prog_n_i && armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      prog_q   <= 1'b1;
      armed    <= 1'b1;
      ready_q  <= 1'b1;
      wcnt     <= '0;
      hcnt     <= '0;
      ptr      <= '0;
      lat_addr <= '0;
      lat_data <= '0;
    end else begin
      prog_q <= prog_n_i;
      if (prog_n_i) armed <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (start_wr) begin
            lat_addr <= addr_i;
            lat_data <= data_i;
            wcnt     <= '0;
            hcnt     <= '0;
            ready_q  <= 1'b0;
            state    <= ST_BUSY;
          end else if (erase_cond) begin
            if (hcnt == HW'(ERASE_HOLD - 1)) begin
              hcnt    <= '0;
              ptr     <= '0;
              armed   <= 1'b0;
              ready_q <= 1'b0;
              state   <= ST_ERASE;
            end else begin
              hcnt <= hcnt + 1'b1;
            end
          end else begin
            hcnt <= '0;
          end
        end
        ST_BUSY: begin
          if (wcnt == CW'(WRITE_CYCLES - 1)) state <= ST_FETCH;
          else wcnt <= wcnt + 1'b1;
        end
        ST_FETCH: state <= ST_COMMIT;
        ST_COMMIT: begin
          ready_q <= 1'b1;
          state   <= ST_IDLE;
        end
        ST_ERASE: begin
          if (ptr == {ADDR_W{1'b1}}) begin
            ready_q <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ready_o    = ready_q;
  assign wr_busy_o  = (state == ST_BUSY) || (state == ST_FETCH) || (state == ST_COMMIT);
  assign lat_addr_o = lat_addr;
  assign poll_bit_o = ~lat_data[DATA_W-1];
  assign b_addr     = (state == ST_ERASE) ? ptr : lat_addr;
  assign b_we       = (state == ST_COMMIT) || (state == ST_ERASE);
  assign b_wd       = (state == ST_ERASE) ? {DATA_W{1'b1}} : (old_q & lat_data);

  // R2: the write timer never runs past its limit
  p_timer_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BUSY) |-> (wcnt < CW'(WRITE_CYCLES)));

  // R6: captured address and data hold while the sequencer is not idle
  p_latch_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> ($stable(lat_addr) && $stable(lat_data)));

  // R8: busy never begins without the high voltage present
  p_hv_needed_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(ready_q) |-> $past(hv_ok_i));

  // R9: an erase sweep only begins while the pulse is held low
  p_erase_held_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ERASE && $past(state) == ST_IDLE) |-> $past(!prog_n_i));
endmodule

// File: rtl/flash_readout.sv
module flash_readout
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 8,
  parameter bit LOW_VPP = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] rd_q,
  input  logic              wr_busy,
  input  logic [ADDR_W-1:0] lat_addr,
  input  logic              poll_bit,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  mode_e             mode_d;
  logic [ADDR_W-1:0] addr_d;
  logic              poll_d, pbit_d;
  logic [DATA_W-1:0] sig_val;

  always_comb begin
    case (addr_d)
      ADDR_W'(12'h030): sig_val = DATA_W'(8'h1E);
      ADDR_W'(12'h031): sig_val = DATA_W'(8'h51);
      ADDR_W'(12'h032): sig_val = LOW_VPP ? DATA_W'(8'h05) : DATA_W'(8'hFF);
      default:          sig_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_d    <= MODE_WRITE;
      addr_d    <= '0;
      poll_d    <= 1'b0;
      pbit_d    <= 1'b0;
      data_o    <= '0;
      data_oe_o <= 1'b0;
    end else begin
      mode_d <= mode_e'(mode_i);
      addr_d <= addr_i;
      poll_d <= wr_busy && (addr_i == lat_addr);
      pbit_d <= poll_bit;
      case (mode_d)
        MODE_VERIFY: begin
          data_o    <= poll_d ? {pbit_d, rd_q[DATA_W-2:0]} : rd_q;
          data_oe_o <= 1'b1;
        end
        MODE_SIG: begin
          data_o    <= sig_val;
          data_oe_o <= 1'b1;
        end
        default: begin
          data_o    <= '0;
          data_oe_o <= 1'b0;
        end
      endcase
    end
  end

  // R11: the bus is quiet whenever it is not enabled
  p_quiet_bus_r11: assert property (@(posedge clk) disable iff (rst)
    !data_oe_o |-> (data_o == '0));

  // R10: signature byte at the first identity location
  p_sig_first_r10: assert property (@(posedge clk) disable iff (rst)
    (mode_d == MODE_SIG && addr_d == ADDR_W'(12'h030)) |=> (data_o == DATA_W'(8'h1E)));
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 18000,
  parameter int ERASE_HOLD   = 120000,
  parameter bit LOW_VPP      = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        mode_i,
  input  logic              hv_ok_i,
  input  logic              prog_n_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              ready_o
);
  logic [DATA_W-1:0] rd_q, b_q, b_wd;
  logic [ADDR_W-1:0] b_addr, lat_addr;
  logic              b_we, wr_busy, poll_bit;

  flash_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rd_addr(addr_i), .rd_q(rd_q),
    .b_addr(b_addr), .b_we(b_we), .b_wd(b_wd), .b_q(b_q)
  );

  flash_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .WRITE_CYCLES(WRITE_CYCLES), .ERASE_HOLD(ERASE_HOLD)
  ) u_ctrl (
    .clk(clk), .rst(rst), .mode_i(mode_i), .hv_ok_i(hv_ok_i),
    .prog_n_i(prog_n_i), .addr_i(addr_i), .data_i(data_i), .old_q(b_q),
    .ready_o(ready_o), .wr_busy_o(wr_busy), .lat_addr_o(lat_addr),
    .poll_bit_o(poll_bit), .b_addr(b_addr), .b_we(b_we), .b_wd(b_wd)
  );

  flash_readout #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOW_VPP(LOW_VPP)) u_readout (
    .clk(clk), .rst(rst), .mode_i(mode_i), .addr_i(addr_i), .rd_q(rd_q),
    .wr_busy(wr_busy), .lat_addr(lat_addr), .poll_bit(poll_bit),
    .data_o(data_o), .data_oe_o(data_oe_o)
  );

  // R3: the array is never written while the block reports ready
  p_no_write_ready_r3: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> !b_we);
endmodule

// File: tb/test_flash_prog_seq.sv
module test_flash_prog_seq;
  localparam int AW = 12;
  localparam int WC = 12;
  localparam int EH = 20;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    data_i = '0;
  logic [1:0]    mode_i = 2'b00;
  logic          hv_ok_i = 1'b0;
  logic          prog_n_i = 1'b1;
  logic [7:0]    data_o;
  logic          data_oe_o, ready_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [DEPTH];

  always #5 clk = ~clk;

  flash_prog_seq #(.WRITE_CYCLES(WC), .ERASE_HOLD(EH)) i_flash_prog_seq (
    .clk(clk), .rst(rst), .addr_i(addr_i), .data_i(data_i), .mode_i(mode_i),
    .hv_ok_i(hv_ok_i), .prog_n_i(prog_n_i), .data_o(data_o),
    .data_oe_o(data_oe_o), .ready_o(ready_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] poll_value(input logic [7:0] old_b, input logic [7:0] new_b);
    return {~new_b[7], old_b[6:0]};
  endfunction

  function automatic logic [7:0] sig_value(input logic [AW-1:0] a);
    case (a)
      12'h030: return 8'h1E;
      12'h031: return 8'h51;
      12'h032: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  task automatic do_read(input logic [1:0] m, input logic [AW-1:0] a,
                         output logic [7:0] v, output logic oe);
    @(negedge clk);
    mode_i = m; addr_i = a;
    @(negedge clk);
    @(negedge clk);
    v = data_o; oe = data_oe_o;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d,
                          input logic [AW-1:0] pa, input bit intrude,
                          input logic [AW-1:0] ia, input logic [7:0] id);
    int low_cnt, k;
    logic [7:0] pv, exp_p;
    @(negedge clk);
    addr_i = a; data_i = d; mode_i = 2'b01; hv_ok_i = 1'b1; prog_n_i = 1'b0;
    @(negedge clk);
    prog_n_i = 1'b1; mode_i = 2'b00; addr_i = pa; data_i = ~d;
    low_cnt = (ready_o == 1'b0) ? 1 : 0;
    k = 0;
    pv = 8'h00;
    while (ready_o == 1'b0 && k < 1000) begin
      @(negedge clk);
      k++;
      if (k == 2) pv = data_o;
      if (intrude && k == 4) begin
        mode_i = 2'b01; addr_i = ia; data_i = id; prog_n_i = 1'b0;
      end
      if (intrude && k == 5) begin
        prog_n_i = 1'b1; mode_i = 2'b00; addr_i = pa;
      end
      if (ready_o == 1'b0) low_cnt++;
    end
    check("R2 busy length", low_cnt, WC + 2);
    exp_p = (pa == a) ? poll_value(model[a], d) : model[pa];
    check((pa == a) ? "R4 poll read" : "R5 other read during busy", pv, exp_p);
    model[a] = model[a] & d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic oe;
    int n, low_cnt;
    bit never_low;
    logic [AW-1:0] a, pa;
    logic [7:0] d;
    void'($urandom(32'h5EED1234));

    repeat (3) @(negedge clk);
    check("R1 ready in reset", ready_o, 1);
    check("R1 oe in reset", data_oe_o, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", ready_o, 1);
    check("R1 data after reset", data_o, 0);

    // R9 short pulse: no erase
    mode_i = 2'b10; hv_ok_i = 1'b1; prog_n_i = 1'b0;
    never_low = 1'b1;
    for (int i = 0; i < EH - 1; i++) begin
      @(negedge clk);
      if (ready_o == 1'b0) never_low = 1'b0;
    end
    prog_n_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      if (ready_o == 1'b0) never_low = 1'b0;
    end
    check("R9 short pulse ignored", never_low, 1);

    // R9 full erase
    prog_n_i = 1'b0;
    n = 0;
    while (ready_o == 1'b1 && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check("R9 hold edges", n, EH);
    prog_n_i = 1'b1; mode_i = 2'b00;
    low_cnt = 1;
    n = 0;
    while (n < 10000) begin
      @(negedge clk);
      n++;
      if (ready_o == 1'b1) break;
      low_cnt++;
    end
    check("R9 erase sweep length", low_cnt, DEPTH);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    foreach (model[i]) if (i == 0 || i == DEPTH - 1 || i == 12'h5A5) begin
      do_read(2'b00, AW'(i), v, oe);
      check("R9 erased byte", v, 8'hFF);
    end

    // R10 signature, R11 enables
    for (int i = 12'h030; i <= 12'h033; i++) begin
      do_read(2'b11, AW'(i), v, oe);
      check("R10 signature byte", v, sig_value(AW'(i)));
      check("R11 oe in signature mode", oe, 1);
    end
    do_read(2'b01, 12'h030, v, oe);
    check("R11 oe in write mode", oe, 0);
    check("R11 data quiet in write mode", v, 0);
    do_read(2'b10, 12'h030, v, oe);
    check("R11 oe in erase mode", oe, 0);

    // R3/R4 directed: blank byte, then overwrite clears bits only
    do_write(12'h100, 8'h3C, 12'h100, 1'b0, '0, '0);
    do_read(2'b00, 12'h100, v, oe);
    check("R3 blank write", v, model[12'h100]);
    check("R11 oe in verify mode", oe, 1);
    do_write(12'h100, 8'hF5, 12'h100, 1'b0, '0, '0);
    do_read(2'b00, 12'h100, v, oe);
    check("R3 AND on non-blank", v, 8'h34);

    // R7 intruding pulse while busy, R6 bus change
    do_write(12'h200, 8'h81, 12'h200, 1'b1, 12'h201, 8'h00);
    do_read(2'b00, 12'h200, v, oe);
    check("R6 latched data kept", v, 8'h81);
    do_read(2'b00, 12'h201, v, oe);
    check("R7 intruder ignored", v, 8'hFF);

    // R8 no high voltage
    @(negedge clk);
    addr_i = 12'h300; data_i = 8'h00; mode_i = 2'b01; hv_ok_i = 1'b0; prog_n_i = 1'b0;
    never_low = 1'b1;
    repeat (4) begin
      @(negedge clk);
      prog_n_i = 1'b1;
      if (ready_o == 1'b0) never_low = 1'b0;
    end
    check("R8 ready stays high", never_low, 1);
    do_read(2'b00, 12'h300, v, oe);
    check("R8 byte unchanged", v, 8'hFF);

    // random writes into a small window
    for (int i = 0; i < 40; i++) begin
      a = AW'(12'h400 + ($urandom % 8));
      d = 8'($urandom);
      pa = ($urandom % 3 == 0) ? AW'(12'h400 + ($urandom % 8)) : a;
      do_write(a, d, pa, 1'b0, '0, '0);
      do_read(2'b00, a, v, oe);
      check("R3 random write", v, model[a]);
    end
    for (int i = 0; i < 8; i++) begin
      do_read(2'b00, AW'(12'h400 + i), v, oe);
      check("R3 window contents", v, model[12'h400 + i]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule